// File: doc/BRIEF.md
# Watchdog Timer with Interrupt-then-Reset Escalation

This block is a watchdog peripheral with one byte-wide control register on a simple write/read port. It counts ticks of a prescaled time base and, when the selected period runs out, it raises an interrupt request, issues a system reset pulse, or does both in sequence. The action on timeout depends on two enable bits and on two inputs from outside the block: a fuse that forces reset behaviour and a flag that says the watchdog is in use as a clock monitor.

Software keeps the watchdog alive by strobing `kick`. Clearing the reset enable and changing the period are guarded by a timed unlock. A change-enable bit must first be written to one, and it opens a window of a fixed number of clocks. In the escalating mode the first expiry only interrupts. Acknowledging that interrupt drops the interrupt enable, so an unserviced or repeated expiry resets the system.

Top module: `wdt_guard`

## Requirements
- R1: After the synchronous reset, `reg_rdata` reads 0x00 when `force_rst` is low, and `irq` and `sys_rst` are low.
- R2: The register reads as {flag[7], irq_enable[6], period[3] at bit 5, change_enable[4], reset_enable[3], period[2:0] at bits 2..0}.
- R3: The timeout period is 2^(BASE_LOG2+P) ticks (one tick for each cycle with `tick` high), where P is the 4-bit period field and values above MAX_SEL count as MAX_SEL. A `kick` cycle zeroes the count and suppresses a timeout in that cycle. The count restarts after each timeout and stays at zero while the watchdog is stopped.
- R4: With interrupts allowed, a timeout sets the flag and does not reset the system when the flag was clear. The flag is cleared by writing a one to bit 7 or by `irq_ack` while it is set. Writing a zero to bit 7 has no effect.
- R5: `irq` is registered. It goes high one clock after flag, interrupt enable and `gie` are all high, provided neither `force_rst` nor `clkmon_on` is high.
- R6: `sys_rst` is a pulse of exactly one clock.
- R7: With both enables set, the first timeout only sets the flag. `irq_ack` clears both the flag and the interrupt enable, so the next timeout pulses `sys_rst`. A timeout while the flag is still set pulses `sys_rst`.
- R8: Setting reset_enable is always accepted. Clearing it, or writing the period field, takes effect only while change_enable is active. Otherwise those bits keep their values.
- R9: Writing change_enable as one keeps it active for exactly 4 clocks after the write edge. Writing it as zero drops it at once.
- R10: While `force_rst` is high the block acts in reset mode whatever the enables say. Bit 3 reads as one, and no interrupt flag or request arises.
- R11: While `clkmon_on` is high the block acts in reset mode and interrupts are disabled. Bit 3 still reads the stored enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| kick | input | 1 | Watchdog restart strobe |
| tick | input | 1 | Prescaled time-base enable |
| irq_ack | input | 1 | Interrupt taken strobe |
| gie | input | 1 | Global interrupt enable |
| force_rst | input | 1 | Fuse forcing reset mode |
| clkmon_on | input | 1 | Clock-monitor use active |
| irq | output | 1 | Timeout interrupt request |
| sys_rst | output | 1 | System reset pulse |

## Verification
The assertions assume that every input is synchronous to `clk` and stable around the rising edge, and that `rst` is held high from time zero until the first edges have passed. The bench changes every input 2 ns after a rising edge and samples at the falling edge. Random register writes keep the period field at 7 or below so that timeouts occur within the run. `force_rst` and `clkmon_on` are toggled rarely and held for many cycles, so the mode changes while the counter is running.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // register bit positions (field placement decoded by software)
  localparam int B_FLAG = 7;
  localparam int B_IE   = 6;
  localparam int B_P3   = 5;
  localparam int B_CE   = 4;
  localparam int B_RE   = 3;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_RST  = 2'd1,
    MODE_IRQ  = 2'd2,
    MODE_BOTH = 2'd3
  } wdt_mode_e;

  function automatic logic [3:0] clamp_sel(input logic [3:0] p, input int unsigned max_sel);
    if (int'(p) > int'(max_sel)) return 4'(max_sel);
    return p;
  endfunction
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
#(
  parameter int CE_HOLD = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] wdata,
  input  logic       ack,
  input  logic       set_flag,
  input  logic       clr_ie,
  output logic       flag,
  output logic       ie,
  output logic       re,
  output logic       ce_active,
  output logic [3:0] psel
);
  localparam int CEW = $clog2(CE_HOLD + 1);

  logic [CEW-1:0] ce_cnt;

  assign ce_active = (ce_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_cnt <= '0;
      re     <= 1'b0;
      ie     <= 1'b0;
      flag   <= 1'b0;
      psel   <= '0;
    end else begin
      // change-enable window
      if (we) ce_cnt <= wdata[B_CE] ? CEW'(CE_HOLD) : '0;
      else if (ce_active) ce_cnt <= ce_cnt - 1'b1;

      // reset enable: set freely, clear only inside the window
      if (we) begin
        if (wdata[B_RE]) re <= 1'b1;
        else if (ce_active) re <= 1'b0;
      end

      if (we && ce_active) psel <= {wdata[B_P3], wdata[2:0]};

      if (clr_ie) ie <= 1'b0;
      else if (we) ie <= wdata[B_IE];

      if (set_flag) flag <= 1'b1;
      else if ((ack && flag) || (we && wdata[B_FLAG])) flag <= 1'b0;
    end
  end

  p_ce_count_r9: assert property (@(posedge clk) disable iff (rst)
    (ce_active && !we) |=> (ce_cnt == CEW'($past(ce_cnt) - 1'b1)));
  p_ce_bound_r9: assert property (@(posedge clk) disable iff (rst)
    int'(ce_cnt) <= CE_HOLD);
  p_psel_locked_r8: assert property (@(posedge clk) disable iff (rst)
    !ce_active |=> $stable(psel));
  p_re_locked_r8: assert property (@(posedge clk) disable iff (rst)
    (!ce_active && re) |=> re);
endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 11,
  parameter int MAX_SEL   = 9
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       tick,
  input  logic       kick,
  input  logic [3:0] psel,
  output logic       timeout
);
  localparam int CW = BASE_LOG2 + MAX_SEL;

  logic [CW-1:0] cnt;
  logic [CW-1:0] term;
  logic [3:0]    sel;

  always_comb begin
    sel  = clamp_sel(psel, MAX_SEL);
    term = {CW{1'b1}} >> (CW - BASE_LOG2 - int'(sel));
  end

  assign timeout = run && tick && !kick && (cnt >= term);

  always_ff @(posedge clk) begin
    if (rst || !run || kick || timeout) cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  p_restart_r3: assert property (@(posedge clk) disable iff (rst)
    timeout |=> (cnt == '0));
  p_stopped_r3: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0));
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 11,
  parameter int MAX_SEL   = 9,
  parameter int CE_HOLD   = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       kick,
  input  logic       tick,
  input  logic       irq_ack,
  input  logic       gie,
  input  logic       force_rst,
  input  logic       clkmon_on,
  output logic       irq,
  output logic       sys_rst
);
  logic       flag, ie, re, ce_active, timeout;
  logic [3:0] psel;
  wdt_mode_e  mode;
  logic       int_ok, rst_ok, run, set_flag, clr_ie, do_rst;

  always_comb begin
    if (force_rst || clkmon_on) mode = MODE_RST;
    else mode = wdt_mode_e'({ie, re});
  end

  assign int_ok   = (mode == MODE_IRQ) || (mode == MODE_BOTH);
  assign rst_ok   = (mode == MODE_RST) || (mode == MODE_BOTH);
  assign run      = (mode != MODE_OFF);
  assign set_flag = timeout && int_ok;
  assign clr_ie   = irq_ack && flag && (mode == MODE_BOTH);
  assign do_rst   = timeout && rst_ok && !(int_ok && !flag);

  wdt_ctrl_reg #(.CE_HOLD(CE_HOLD)) u_reg (
    .clk(clk), .rst(rst), .we(reg_we), .wdata(reg_wdata), .ack(irq_ack),
    .set_flag(set_flag), .clr_ie(clr_ie), .flag(flag), .ie(ie), .re(re),
    .ce_active(ce_active), .psel(psel)
  );

  wdt_tick_counter #(.BASE_LOG2(BASE_LOG2), .MAX_SEL(MAX_SEL)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .tick(tick), .kick(kick),
    .psel(psel), .timeout(timeout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_rst <= 1'b0;
      irq     <= 1'b0;
    end else begin
      sys_rst <= do_rst;
      irq     <= flag && ie && gie && !force_rst && !clkmon_on;
    end
  end

  assign reg_rdata = {flag, ie, psel[3], ce_active, re | force_rst, psel[2:0]};

  p_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    sys_rst |=> !sys_rst);
  p_irq_flag_r5: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(flag));
  p_force_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    force_rst |=> !irq);
  p_flag_set_r4: assert property (@(posedge clk) disable iff (rst)
    (timeout && int_ok) |=> flag);
  p_first_no_rst_r7: assert property (@(posedge clk) disable iff (rst)
    (timeout && int_ok && !flag) |=> !sys_rst);
endmodule

// File: tb/test_wdt_guard.sv
module test_wdt_guard;
  localparam int BASE = 3;
  localparam int MAXS = 9;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       kick = 1'b0, tick = 1'b1, irq_ack = 1'b0, gie = 1'b1;
  logic       force_rst = 1'b0, clkmon_on = 1'b0;
  logic       irq, sys_rst;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdt_guard #(.BASE_LOG2(BASE), .MAX_SEL(MAXS), .CE_HOLD(4)) i_wdt_guard (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .kick(kick), .tick(tick), .irq_ack(irq_ack),
    .gie(gie), .force_rst(force_rst), .clkmon_on(clkmon_on),
    .irq(irq), .sys_rst(sys_rst)
  );

  // reference model built from the requirements
  logic       m_flag, m_ie, m_re, m_rst, m_irq;
  logic [3:0] m_p;
  int         m_ce, m_cnt;

  function automatic int term_of(input logic [3:0] p);
    int s = (int'(p) > MAXS) ? MAXS : int'(p);
    return (1 << (BASE + s)) - 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_flag <= 0; m_ie <= 0; m_re <= 0; m_rst <= 0; m_irq <= 0;
      m_p <= 0; m_ce <= 0; m_cnt <= 0;
    end else begin
      bit iok, rok, run, to, ce;
      iok = m_ie && !force_rst && !clkmon_on;
      rok = m_re || force_rst || clkmon_on;
      run = iok || rok;
      to  = run && tick && !kick && (m_cnt >= term_of(m_p));
      ce  = (m_ce != 0);
      m_cnt <= (!run || kick || to) ? 0 : (tick ? m_cnt + 1 : m_cnt);
      m_rst <= to && rok && !(iok && !m_flag);
      m_irq <= m_flag && m_ie && gie && !force_rst && !clkmon_on;
      m_ce  <= reg_we ? (reg_wdata[4] ? 4 : 0) : (ce ? m_ce - 1 : 0);
      if (reg_we) begin
        if (reg_wdata[3]) m_re <= 1;
        else if (ce) m_re <= 0;
        if (ce) m_p <= {reg_wdata[5], reg_wdata[2:0]};
      end
      if (irq_ack && m_flag && iok && m_re) m_ie <= 0;
      else if (reg_we) m_ie <= reg_wdata[6];
      if (to && iok) m_flag <= 1;
      else if ((irq_ack && m_flag) || (reg_we && reg_wdata[7])) m_flag <= 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [7:0] er;
      er = {m_flag, m_ie, m_p[3], m_ce != 0, m_re | force_rst, m_p[2:0]};
      chk(reg_rdata === er, "R2 readback", reg_rdata, er);
      chk(irq === m_irq, "R5 irq", irq, m_irq);
      chk(sys_rst === m_rst, "R6 sys_rst", sys_rst, m_rst);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [7:0] v);
    step(); reg_we = 1'b1; reg_wdata = v;
    step(); reg_we = 1'b0;
  endtask

  task automatic wait_for_rst(output bit seen);
    seen = 0;
    for (int i = 0; i < 40 && !seen; i++) begin
      @(negedge clk); if (sys_rst) seen = 1;
    end
  endtask

  task automatic wait_for_flag(output bit seen);
    seen = 0;
    for (int i = 0; i < 40 && !seen; i++) begin
      @(negedge clk); if (reg_rdata[7]) seen = 1;
    end
  endtask

  initial begin
    bit seen;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    chk(reg_rdata == 8'h00, "R1 rdata", reg_rdata, 0);
    chk(!irq && !sys_rst, "R1 outputs", {irq, sys_rst}, 0);

    // R8: set re freely, clear and period locked
    wr(8'h08); @(negedge clk);
    chk(reg_rdata == 8'h08, "R8 set re", reg_rdata, 8'h08);
    wr(8'h07); @(negedge clk);
    chk(reg_rdata == 8'h08, "R8 locked clear/period", reg_rdata, 8'h08);

    // R9: window length
    wr(8'h18); @(negedge clk);
    chk(reg_rdata[4] == 1, "R9 ce set", reg_rdata[4], 1);
    repeat (3) @(posedge clk); @(negedge clk);
    chk(reg_rdata[4] == 1, "R9 ce 4th cycle", reg_rdata[4], 1);
    @(posedge clk); @(negedge clk);
    chk(reg_rdata[4] == 0, "R9 ce expired", reg_rdata[4], 0);

    // R8: unlocked clear of re and period change
    wr(8'h18); wr(8'h12); @(negedge clk);
    chk(reg_rdata == 8'h12, "R8 unlocked write", reg_rdata, 8'h12);
    repeat (5) step();

    // R3/R4/R5: interrupt mode, period 8 ticks
    wr(8'h10); wr(8'h40);
    repeat (7) @(posedge clk); @(negedge clk);
    chk(reg_rdata[7] == 0, "R3 before period", reg_rdata[7], 0);
    @(posedge clk); @(negedge clk);
    chk(reg_rdata[7] == 1, "R3 R4 flag at period", reg_rdata[7], 1);
    chk(sys_rst == 0, "R4 no reset", sys_rst, 0);
    @(posedge clk); @(negedge clk);
    chk(irq == 1, "R5 irq raised", irq, 1);
    #2 kick = 1'b1;
    wr(8'h40); @(negedge clk);
    chk(reg_rdata[7] == 1, "R4 write zero ignored", reg_rdata[7], 1);
    wr(8'hC0); @(negedge clk);
    chk(reg_rdata == 8'h40, "R4 write one clears", reg_rdata, 8'h40);

    // R7: escalation with acknowledge
    wr(8'h48); @(negedge clk);
    chk(reg_rdata == 8'h48, "R7 both enables", reg_rdata, 8'h48);
    step(); kick = 1'b0;
    wait_for_flag(seen);
    chk(seen, "R7 first timeout flags", seen, 1);
    chk(sys_rst == 0, "R7 first timeout no reset", sys_rst, 0);
    step(); irq_ack = 1'b1; step(); irq_ack = 1'b0;
    @(negedge clk);
    chk(reg_rdata == 8'h08, "R7 ack clears ie and flag", reg_rdata, 8'h08);
    wait_for_rst(seen);
    chk(seen, "R7 reset after ack", seen, 1);
    @(negedge clk);
    chk(sys_rst == 0, "R6 single pulse", sys_rst, 0);
    wr(8'h48);
    wait_for_flag(seen);
    chk(seen, "R7 flag again", seen, 1);
    wait_for_rst(seen);
    chk(seen, "R7 unserviced reset", seen, 1);
    chk(reg_rdata[7] == 1, "R7 flag kept", reg_rdata[7], 1);

    // R10: forced reset mode
    step(); kick = 1'b1;
    wr(8'h80); wr(8'h10); wr(8'h40); @(negedge clk);
    chk(reg_rdata == 8'h40, "R8 re cleared in window", reg_rdata, 8'h40);
    step(); force_rst = 1'b1; @(negedge clk);
    chk(reg_rdata == 8'h48, "R10 re reads one", reg_rdata, 8'h48);
    step(); kick = 1'b0;
    wait_for_rst(seen);
    chk(seen, "R10 forced reset", seen, 1);
    chk(reg_rdata[7] == 0 && irq == 0, "R10 no interrupt", {reg_rdata[7], irq}, 0);
    step(); force_rst = 1'b0; kick = 1'b1;

    // R11: clock-monitor use
    step(); clkmon_on = 1'b1; @(negedge clk);
    chk(reg_rdata[3] == 0, "R11 stored re", reg_rdata[3], 0);
    step(); kick = 1'b0;
    wait_for_rst(seen);
    chk(seen, "R11 reset mode", seen, 1);
    chk(reg_rdata[7] == 0, "R11 no flag", reg_rdata[7], 0);
    step(); clkmon_on = 1'b0; kick = 1'b1;
    wr(8'h00);

    // R3: reserved period value acts as the largest
    wr(8'h10); wr(8'h2F); @(negedge clk);
    chk(reg_rdata == 8'h2F, "R2 field layout", reg_rdata, 8'h2F);
    step(); kick = 1'b0;
    repeat (4095) @(posedge clk); @(negedge clk);
    chk(sys_rst == 0, "R3 clamp before", sys_rst, 0);
    @(posedge clk); @(negedge clk);
    chk(sys_rst == 1, "R3 clamp period", sys_rst, 1);

    // random phase checked by the model
    for (int n = 0; n < 6000; n++) begin
      step();
      reg_we    = ($urandom % 16) == 0;
      reg_wdata = 8'($urandom) & 8'hDF;
      kick      = ($urandom % 40) == 0;
      tick      = ($urandom % 4) != 0;
      irq_ack   = ($urandom % 25) == 0;
      if ($urandom % 10 == 0) gie = ~gie;
      if ($urandom % 300 == 0) force_rst = ~force_rst;
      if ($urandom % 400 == 0) clkmon_on = ~clkmon_on;
    end
    step();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule